// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and the next memory level and holds stores that have not yet reached memory. Each slot covers one aligned block of four 8-byte words and keeps a valid bit per word. A store whose block is already pending in an open slot is folded into that slot rather than taking a new one. Slots leave the buffer oldest first, each as a single block-wide write with a word mask.

A read miss can probe the buffer with a combinational lookup before it goes to memory. If the requested word is pending, the buffer returns the newest copy. Otherwise the lookup reports a miss and memory supplies the data. A store to a new block when all slots are occupied is refused through a stall output, and the store source must retry it.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `buf_full`, `st_stall`, `drain_valid` and `lk_hit` are all 0.
- R2: An address splits into a block tag (`addr[31:5]`), a word index (`addr[4:3]`) and ignored byte bits (`addr[2:0]`). A store that opens a new slot sets only the mask bit of its own word. The other data lanes of that slot read zero.
- R3: A store whose tag matches an open (not draining) pending slot is merged into that slot. Stores to 100, 108, 116 and 124 fill one slot for block 96 with mask `1111`.
- R4: A store to a word that is already valid in an open slot replaces the older value in place and uses no new slot.
- R5: There are 4 slots. `buf_full` is 1 when all are occupied. In that state, a store to a block with no open slot raises `st_stall` in the same cycle and is not accepted. A store that merges is still accepted.
- R6: Draining uses a handshake. When the buffer is idle and non-empty, a cycle with `drain_req` high makes `drain_valid` high from the next cycle on. `drain_valid` stays high until a cycle with `drain_ack` high removes the slot. Slots drain in allocation order.
- R7: While a slot is draining, its address, mask and data hold steady. A store to the same block opens a new slot instead of merging into it.
- R8: With `lk_valid` high, `lk_hit` is 1 only when a pending slot holds the tag and has the addressed word's valid bit set. `lk_data` is then the value from the youngest such slot. With `lk_valid` low, `lk_hit` is 0.
- R9: During a drain, `drain_addr` is the block base (low 5 bits zero). Word i sits in `drain_data[64*i +: 64]` and `drain_mask[i]` marks it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store word |
| st_stall | output | 1 | Store refused this cycle (full, no merge slot) |
| buf_full | output | 1 | All slots occupied |
| lk_valid | input | 1 | Read-miss lookup request |
| lk_addr | input | 32 | Lookup byte address |
| lk_hit | output | 1 | Lookup found a valid pending word |
| lk_data | output | 64 | Pending word for a lookup hit |
| drain_req | input | 1 | Memory ready to take a block |
| drain_ack | input | 1 | Memory accepted the draining block |
| drain_valid | output | 1 | A block is being drained |
| drain_addr | output | 32 | Base address of the draining block |
| drain_data | output | 256 | Four words of the draining block |
| drain_mask | output | 4 | Valid word lanes of the draining block |

## Verification
Merging is exercised with four stores that walk through the words of one block. This separates true coalescing from one-slot-per-store allocation, which would fill the buffer. Stores to four distinct blocks followed by a fifth fill the buffer and show the stall. A merge issued at full capacity shows that a stall only occurs when there is no open slot. Two stores to one word show overwrite in place, and a probe of a neighbouring word shows that a per-word valid bit, not the tag alone, decides a hit. Stores made while a drain is in progress show that the draining slot stays frozen and that a lookup returns the youngest copy when two slots share a block.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    // Drain engine state: idle, or holding the head slot locked for memory
    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } drain_st_e;

endpackage

// File: rtl/mwb_tag_cmp.sv
module mwb_tag_cmp #(
    parameter int TAG_W   = 27,
    parameter int ENTRIES = 4
) (
    input  logic [TAG_W-1:0]              probe,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0]            live,
    output logic [ENTRIES-1:0]            hit
);

    // One comparator per slot, all in parallel
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit[e] = live[e] && (tags[e] == probe);
    end

endmodule

// File: rtl/mwb_lookup.sv
module mwb_lookup #(
    parameter int WORD_W    = 64,
    parameter int BLK_WORDS = 4,
    parameter int ENTRIES   = 4,
    localparam int WIDX_W   = $clog2(BLK_WORDS),
    localparam int PTR_W    = $clog2(ENTRIES)
) (
    input  logic                                       req,
    input  logic [WIDX_W-1:0]                          widx,
    input  logic [ENTRIES-1:0]                         tag_hit,
    input  logic [ENTRIES-1:0][BLK_WORDS-1:0]          wmask,
    input  logic [ENTRIES-1:0][BLK_WORDS-1:0][WORD_W-1:0] dat,
    input  logic [PTR_W-1:0]                           head,
    output logic                                       hit,
    output logic [WORD_W-1:0]                          data
);

    logic [PTR_W-1:0] slot;

    // Walk from oldest to youngest; a later match overrides, so youngest wins
    always_comb begin
        hit  = 1'b0;
        data = '0;
        slot = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            slot = head + PTR_W'(k);
            if (req && tag_hit[slot] && wmask[slot][widx]) begin
                hit  = 1'b1;
                data = dat[slot][widx];
            end
        end
    end

endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer
    import mwb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 64,
    parameter int BLK_WORDS = 4,   // power of two
    parameter int ENTRIES   = 4    // power of two
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        st_valid,
    input  logic [ADDR_W-1:0]           st_addr,
    input  logic [WORD_W-1:0]           st_data,
    output logic                        st_stall,
    output logic                        buf_full,
    input  logic                        lk_valid,
    input  logic [ADDR_W-1:0]           lk_addr,
    output logic                        lk_hit,
    output logic [WORD_W-1:0]           lk_data,
    input  logic                        drain_req,
    input  logic                        drain_ack,
    output logic                        drain_valid,
    output logic [ADDR_W-1:0]           drain_addr,
    output logic [BLK_WORDS*WORD_W-1:0] drain_data,
    output logic [BLK_WORDS-1:0]        drain_mask
);

    localparam int BYTE_OFF = $clog2(WORD_W / 8);
    localparam int WIDX_W   = $clog2(BLK_WORDS);
    localparam int BLK_OFF  = BYTE_OFF + WIDX_W;
    localparam int TAG_W    = ADDR_W - BLK_OFF;
    localparam int PTR_W    = $clog2(ENTRIES);
    localparam int CNT_W    = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic [ENTRIES-1:0]                            vld;
        logic [ENTRIES-1:0][TAG_W-1:0]                 tag;
        logic [ENTRIES-1:0][BLK_WORDS-1:0]             wm;
        logic [ENTRIES-1:0][BLK_WORDS-1:0][WORD_W-1:0] dat;
        logic [PTR_W-1:0]                              head;
        logic [PTR_W-1:0]                              tail;
        logic [CNT_W-1:0]                              cnt;
        drain_st_e                                     dst;
    } state_t;

    state_t q, d;

    logic [TAG_W-1:0]   st_tag, lk_tag;
    logic [WIDX_W-1:0]  st_widx, lk_widx;
    logic [ENTRIES-1:0] locked_d, open_q, merge_vec, lk_vec;
    logic               merge_hit, accept, alloc, pop;
    logic [PTR_W-1:0]   merge_idx, tgt_idx;

    assign st_tag  = st_addr[ADDR_W-1:BLK_OFF];
    assign st_widx = st_addr[BLK_OFF-1:BYTE_OFF];
    assign lk_tag  = lk_addr[ADDR_W-1:BLK_OFF];
    assign lk_widx = lk_addr[BLK_OFF-1:BYTE_OFF];

    // The head slot is frozen while it is being drained
    assign locked_d = (q.dst == DR_BUSY) ? (ENTRIES'(1) << q.head) : '0;
    assign open_q   = q.vld & ~locked_d;

    mwb_tag_cmp #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_st_cmp (
        .probe (st_tag),
        .tags  (q.tag),
        .live  (open_q),
        .hit   (merge_vec)
    );

    mwb_tag_cmp #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_lk_cmp (
        .probe (lk_tag),
        .tags  (q.tag),
        .live  (q.vld),
        .hit   (lk_vec)
    );

    mwb_lookup #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .ENTRIES(ENTRIES)) u_lookup (
        .req     (lk_valid),
        .widx    (lk_widx),
        .tag_hit (lk_vec),
        .wmask   (q.wm),
        .dat     (q.dat),
        .head    (q.head),
        .hit     (lk_hit),
        .data    (lk_data)
    );

    always_comb begin
        d = q;

        // At most one open slot holds a given block
        merge_hit = |merge_vec;
        merge_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (merge_vec[e]) merge_idx = PTR_W'(e);
        end

        buf_full = (q.cnt == CNT_W'(ENTRIES));
        st_stall = st_valid && !merge_hit && buf_full;
        accept   = st_valid && !st_stall;
        alloc    = accept && !merge_hit;
        pop      = (q.dst == DR_BUSY) && drain_ack;
        tgt_idx  = merge_hit ? merge_idx : q.tail;

        if (alloc) begin
            d.vld[q.tail] = 1'b1;
            d.tag[q.tail] = st_tag;
            d.wm[q.tail]  = '0;
            d.dat[q.tail] = '0;
            d.tail        = q.tail + PTR_W'(1);
        end
        if (accept) begin
            d.wm[tgt_idx][st_widx]  = 1'b1;
            d.dat[tgt_idx][st_widx] = st_data;
        end

        if (pop) begin
            d.vld[q.head] = 1'b0;
            d.head        = q.head + PTR_W'(1);
            d.dst         = DR_IDLE;
        end else if ((q.dst == DR_IDLE) && drain_req && (q.cnt != '0)) begin
            d.dst = DR_BUSY;
        end

        d.cnt = q.cnt + CNT_W'(alloc) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign drain_valid = (q.dst == DR_BUSY);
    assign drain_addr  = {q.tag[q.head], BLK_OFF'(0)};
    assign drain_data  = q.dat[q.head];
    assign drain_mask  = q.wm[q.head];

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(ENTRIES));

    // R5
    occupancy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.vld) == int'(q.cnt));

    // R5
    stall_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> buf_full);

    // R7
    drain_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ack) |=> (drain_valid && $stable(drain_addr)
                                         && $stable(drain_mask) && $stable(drain_data)));

    // R6
    drain_has_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> (drain_mask != '0));

    // R6
    drain_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && drain_ack) |=> !drain_valid);

    // R8
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid);

endmodule

// File: tb/merge_write_buffer_tb.sv
module merge_write_buffer_tb;

    localparam time CLK_P = 20ns;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         st_valid;
    logic [31:0]  st_addr;
    logic [63:0]  st_data;
    logic         st_stall;
    logic         buf_full;
    logic         lk_valid;
    logic [31:0]  lk_addr;
    logic         lk_hit;
    logic [63:0]  lk_data;
    logic         drain_req;
    logic         drain_ack;
    logic         drain_valid;
    logic [31:0]  drain_addr;
    logic [255:0] drain_data;
    logic [3:0]   drain_mask;

    int checks = 0;
    int errors = 0;
    logic stall_seen;

    always #(CLK_P / 2) clk = ~clk;

    merge_write_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_stall(st_stall), .buf_full(buf_full),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .drain_req(drain_req), .drain_ack(drain_ack), .drain_valid(drain_valid),
        .drain_addr(drain_addr), .drain_data(drain_data), .drain_mask(drain_mask)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic store(input logic [31:0] a, input logic [63:0] v);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = v;
        #2 stall_seen = st_stall;
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    task automatic lookup_expect(input string req, input logic [31:0] a,
                                 input logic h, input logic [63:0] v);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        #2;
        chk(req, "lk_hit", lk_hit, h);
        if (h) chk(req, "lk_data", lk_data, v);
        lk_valid = 1'b0;
    endtask

    task automatic drain_start(input string req, input logic [31:0] a,
                               input logic [3:0] m, input logic [255:0] dd);
        @(negedge clk); drain_req = 1'b1;
        @(posedge clk); #1 drain_req = 1'b0;
        @(negedge clk);
        chk(req, "drain_valid", drain_valid, 1'b1);
        chk(req, "drain_addr", drain_addr, a);
        chk(req, "drain_mask", drain_mask, m);
        chk(req, "drain_data", drain_data, dd);
    endtask

    task automatic drain_finish(input string req);
        @(negedge clk); drain_ack = 1'b1;
        @(posedge clk); #1 drain_ack = 1'b0;
        @(negedge clk);
        chk(req, "drain_valid after ack", drain_valid, 1'b0);
    endtask

    // R1
    task automatic t_reset;
        @(negedge clk);
        chk("R1", "buf_full", buf_full, 1'b0);
        chk("R1", "st_stall", st_stall, 1'b0);
        chk("R1", "drain_valid", drain_valid, 1'b0);
        lookup_expect("R1", 32'h0, 1'b0, 64'h0);
    endtask

    // R3, R9: four words of block 96 coalesce into one slot
    task automatic t_merge;
        store(32'd100, 64'hA0);
        store(32'd108, 64'hA1);
        store(32'd116, 64'hA2);
        store(32'd124, 64'hA3);
        @(negedge clk);
        chk("R3", "buf_full after merges", buf_full, 1'b0);
        lookup_expect("R3", 32'd116, 1'b1, 64'hA2);
        drain_start("R3_R9", 32'd96, 4'b1111, {64'hA3, 64'hA2, 64'hA1, 64'hA0});
        drain_finish("R6");
        lookup_expect("R6", 32'd116, 1'b0, 64'h0);
    endtask

    // R5, R2, R6: distinct blocks fill the buffer, stall, merge at full
    task automatic t_capacity;
        store(32'h1000, 64'hB0);
        store(32'h2000, 64'hB1);
        store(32'h3004, 64'hB2);
        store(32'h4000, 64'hB3);
        @(negedge clk);
        chk("R5", "buf_full", buf_full, 1'b1);
        store(32'h5000, 64'hB4);
        chk("R5", "stall on new block when full", stall_seen, 1'b1);
        lookup_expect("R5", 32'h5000, 1'b0, 64'h0);
        store(32'h2008, 64'hB5);
        chk("R5", "merge accepted when full", stall_seen, 1'b0);
        drain_start("R6_R2", 32'h1000, 4'b0001, {192'h0, 64'hB0});
        drain_finish("R6");
        drain_start("R6", 32'h2000, 4'b0011, {128'h0, 64'hB5, 64'hB1});
        drain_finish("R6");
        drain_start("R2", 32'h3000, 4'b0001, {192'h0, 64'hB2});
        drain_finish("R6");
        drain_start("R6", 32'h4000, 4'b0001, {192'h0, 64'hB3});
        drain_finish("R6");
        chk("R6", "buf_full after drain", buf_full, 1'b0);
    endtask

    // R4, R8: same-word overwrite; neighbour word not valid
    task automatic t_overwrite;
        store(32'h700, 64'hC0);
        store(32'h700, 64'hC1);
        lookup_expect("R4", 32'h700, 1'b1, 64'hC1);
        lookup_expect("R8", 32'h708, 1'b0, 64'h0);
        drain_start("R4", 32'h700, 4'b0001, {192'h0, 64'hC1});
        drain_finish("R4");
    endtask

    // R7, R8: locked draining slot, youngest copy wins
    task automatic t_locked;
        store(32'h800, 64'hD0);
        drain_start("R7", 32'h800, 4'b0001, {192'h0, 64'hD0});
        store(32'h808, 64'hD1);
        store(32'h800, 64'hD2);
        @(negedge clk);
        chk("R7", "draining mask unchanged", drain_mask, 4'b0001);
        chk("R7", "draining data unchanged", drain_data, {192'h0, 64'hD0});
        lookup_expect("R8", 32'h800, 1'b1, 64'hD2);
        lookup_expect("R8", 32'h808, 1'b1, 64'hD1);
        @(negedge clk);
        lk_valid = 1'b0; lk_addr = 32'h808;
        #2 chk("R8", "no hit without lk_valid", lk_hit, 1'b0);
        drain_finish("R7");
        drain_start("R7", 32'h800, 4'b0011, {128'h0, 64'hD1, 64'hD2});
        drain_finish("R7");
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0;
        lk_valid = 1'b0; lk_addr = '0; drain_req = 1'b0; drain_ack = 1'b0;
        stall_seen = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_merge();
        t_capacity();
        t_overwrite();
        t_locked();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule